// File: doc/BRIEF.md
# Linked Command List Executor

This block runs a chain of command blocks that software has placed in memory. Each block holds a status word at its base address and a command word two bytes above it. A 32-bit link to the following block sits at offsets +4 and +6, and any parameters start at +8. Memory is reached through a request/acknowledge port that carries 16-bit big-endian words at byte addresses. The lower half of every 32-bit value sits at the lower address.

For each block the engine first marks the block busy and reads its command. It then hands the work to an external handler through a done handshake, or does the work itself, writes a completion status and follows the link. Flags in the command word can end the list, suspend the unit or request an interrupt. The engine reports the state of the command unit, a completion flag, an interrupt pulse and a strobe that tells the surrounding controller to refresh its own status word. A start pulse begins a walk at a given head pointer, or resumes the walk after a suspension.

Top module: `cle_exec`

## Requirements
- R1: After reset, `cu_state` is 0 (idle), `cx_flag`, `irq` and `stat_upd` are low, and neither `mem_req` nor `hnd_req` is asserted.
- R2: Each block starts with a write of 0x4000 (busy) to the block base. Operations 0 to 5 end with a write of 0xA000 (complete plus OK) to the block base. The busy write comes before the command read at base+2, and the final status write comes before the link reads.
- R3: Operation codes 6 and 7, taken from command bits [2:0], get the final status 0x8000 (complete, OK clear) with no handler request and no parameter access.
- R4: The next pointer is read as a low half at base+4 and a high half at base+6. A value of 0x00000000 or 0xFFFFFFFF ends the walk, and `cu_state` then returns to 0.
- R5: When command bit 15 is set, the walk ends after that block even if the link is non-null.
- R6: When command bit 14 is set, `cu_state` becomes 1 (suspended) after that block and no further memory access is made. A later `start` resumes at that block's link if the link is non-null; otherwise it starts at `head_ptr`.
- R7: When command bit 13 is set, `cx_flag` goes high and `irq` pulses for one cycle after the block. A block with bit 13 clear drives `cx_flag` low.
- R8: Configure (op 2) reads the word at base+8 and issues a handler request with op 2. The length is the low nibble of the byte at base+8 (bits [11:8] of that word), raised to at least 4 and capped at CFG_BYTES.
- R9: Address setup (op 1) requests the handler with length 6. Multicast list (op 3) and transmit (op 4) request it with length 0. `hnd_addr` carries the block base, and the final status is written only after `hnd_done`.
- R10: Link test (op 5) writes 0x8000 when `link_up` is high, or 0x0000 when it is low, to base+8, and then writes 0x0000 to base+10.
- R11: `stat_upd` pulses for one cycle after each completed block, in the same cycle as any `irq` pulse.
- R12: `cu_state` is 2 (active) throughout a walk. A `start` that arrives while the unit is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin or resume a walk |
| head_ptr | input | ADDR_W | First block address for a fresh walk |
| link_up | input | 1 | Link state reported by the link test |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| hnd_req | output | 1 | Handler request, held until done |
| hnd_op | output | 3 | Operation code for the handler |
| hnd_len | output | 4 | Parameter byte count for the handler |
| hnd_addr | output | ADDR_W | Base of the block being executed |
| hnd_done | input | 1 | Handler finished |
| cu_state | output | 2 | 0 idle, 1 suspended, 2 active |
| cx_flag | output | 1 | Command-complete-with-interrupt flag |
| irq | output | 1 | One-cycle interrupt pulse |
| stat_upd | output | 1 | One-cycle status-refresh strobe |

## Verification
The bench targets the two null encodings, and the case of an end-of-list flag on a block whose link is still valid. A design that got either wrong would read a block past the end of the list. It suspends a walk and restarts it with a different head pointer, which catches a design that restarts from the head. A start pulse arrives in the middle of a walk, which catches a design that re-enters and repeats the busy write. The configure counts 2 and 15 sit on either side of the clamp, so a design without the clamp produces the wrong handler length. Operation codes 6 and 7 expose a design that sets OK for them or waits on a handler that is never asked. The link test runs with the link both up and down, and a swapped half or a missing high-word write shows up as a wrong memory write.

// File: rtl/cle_pkg.sv
`timescale 1ns/1ps
package cle_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_BUSY, ST_CMD, ST_CFG, ST_HND,
    ST_LNK0, ST_LNK1, ST_STAT, ST_PLO, ST_PHI
  } cle_state_t;

  localparam logic [1:0] CU_IDLE = 2'd0;
  localparam logic [1:0] CU_SUSP = 2'd1;
  localparam logic [1:0] CU_ACT  = 2'd2;

  localparam logic [2:0] OP_NOP   = 3'd0;
  localparam logic [2:0] OP_ADDR  = 3'd1;
  localparam logic [2:0] OP_CFG   = 3'd2;
  localparam logic [2:0] OP_MCAST = 3'd3;
  localparam logic [2:0] OP_TX    = 3'd4;
  localparam logic [2:0] OP_LINK  = 3'd5;

  localparam logic [15:0] W_BUSY = 16'h4000;
  localparam logic [15:0] W_DONE = 16'h8000;
  localparam logic [15:0] W_OK   = 16'h2000;
  localparam logic [15:0] W_LINK = 16'h8000;

  localparam int F_EOL  = 15;
  localparam int F_SUSP = 14;
  localparam int F_INT  = 13;
endpackage

// File: rtl/cle_len_calc.sv
`timescale 1ns/1ps
module cle_len_calc #(
  parameter int CFG_BYTES  = 14,
  parameter int ADDR_BYTES = 6
) (
  input  logic [2:0] op,
  input  logic [3:0] nib,
  output logic [3:0] len
);
  import cle_pkg::*;
  localparam logic [3:0] MAXB = 4'(CFG_BYTES);
  localparam logic [3:0] MINB = 4'd4;
  localparam logic [3:0] SAB  = 4'(ADDR_BYTES);

  always_comb begin
    len = '0;
    if (op == OP_ADDR) len = SAB;
    else if (op == OP_CFG) begin
      if (nib < MINB)      len = MINB;
      else if (nib > MAXB) len = MAXB;
      else                 len = nib;
    end
  end

  initial begin
    assert (CFG_BYTES >= 4 && CFG_BYTES <= 15)
      else $error("CFG_BYTES out of range");
  end
endmodule

// File: rtl/cle_link_eval.sv
`timescale 1ns/1ps
module cle_link_eval #(
  parameter int ADDR_W = 32
) (
  input  logic [15:0]       lo,
  input  logic [15:0]       hi,
  input  logic              eol,
  output logic              is_null,
  output logic [ADDR_W-1:0] next
);
  logic [31:0] full;
  assign full    = {hi, lo};
  assign is_null = eol || (full == 32'h0) || (full == 32'hFFFF_FFFF);
  assign next    = full[ADDR_W-1:0];
endmodule

// File: rtl/cle_exec.sv
`timescale 1ns/1ps
module cle_exec #(
  parameter int ADDR_W    = 32,
  parameter int CFG_BYTES = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] head_ptr,
  input  logic              link_up,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              hnd_req,
  output logic [2:0]        hnd_op,
  output logic [3:0]        hnd_len,
  output logic [ADDR_W-1:0] hnd_addr,
  input  logic              hnd_done,
  output logic [1:0]        cu_state,
  output logic              cx_flag,
  output logic              irq,
  output logic              stat_upd
);
  import cle_pkg::*;
  localparam logic [ADDR_W-1:0] OFS_CMD  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_LLO  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_LHI  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] OFS_PAR  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_PAR2 = ADDR_W'(10);

  cle_state_t        st;
  logic [ADDR_W-1:0] blk, nxt;
  logic              nxt_vld;
  logic [2:0]        c_op;
  logic              c_eol, c_susp, c_int;
  logic [3:0]        cfg_nib;
  logic [15:0]       ptr_lo;
  logic              lk_null;
  logic [ADDR_W-1:0] lk_next;

  cle_len_calc #(.CFG_BYTES(CFG_BYTES), .ADDR_BYTES(6)) u_len (
    .op(c_op), .nib(cfg_nib), .len(hnd_len)
  );

  cle_link_eval #(.ADDR_W(ADDR_W)) u_link (
    .lo(ptr_lo), .hi(mem_rdata), .eol(c_eol),
    .is_null(lk_null), .next(lk_next)
  );

  // memory and handler requests decoded from state registers only
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = blk;
    mem_wdata = '0;
    case (st)
      ST_BUSY: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = W_BUSY; end
      ST_CMD:  begin mem_req = 1'b1; mem_addr = blk + OFS_CMD; end
      ST_CFG:  begin mem_req = 1'b1; mem_addr = blk + OFS_PAR; end
      ST_LNK0: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = blk + OFS_PAR;
        mem_wdata = link_up ? W_LINK : 16'h0;
      end
      ST_LNK1: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = blk + OFS_PAR2; end
      ST_STAT: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_wdata = W_DONE | ((c_op <= OP_LINK) ? W_OK : 16'h0);
      end
      ST_PLO:  begin mem_req = 1'b1; mem_addr = blk + OFS_LLO; end
      ST_PHI:  begin mem_req = 1'b1; mem_addr = blk + OFS_LHI; end
      default: ;
    endcase
  end

  assign hnd_req  = (st == ST_HND);
  assign hnd_op   = c_op;
  assign hnd_addr = blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      blk      <= '0;
      nxt      <= '0;
      nxt_vld  <= 1'b0;
      c_op     <= '0;
      c_eol    <= 1'b0;
      c_susp   <= 1'b0;
      c_int    <= 1'b0;
      cfg_nib  <= '0;
      ptr_lo   <= '0;
      cu_state <= CU_IDLE;
      cx_flag  <= 1'b0;
      irq      <= 1'b0;
      stat_upd <= 1'b0;
    end else begin
      irq      <= 1'b0;
      stat_upd <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          blk      <= nxt_vld ? nxt : head_ptr;
          nxt_vld  <= 1'b0;
          cu_state <= CU_ACT;
          st       <= ST_BUSY;
        end
        ST_BUSY: if (mem_ack) st <= ST_CMD;
        ST_CMD: if (mem_ack) begin
          c_op   <= mem_rdata[2:0];
          c_eol  <= mem_rdata[F_EOL];
          c_susp <= mem_rdata[F_SUSP];
          c_int  <= mem_rdata[F_INT];
          case (mem_rdata[2:0])
            OP_ADDR, OP_MCAST, OP_TX: st <= ST_HND;
            OP_CFG:                   st <= ST_CFG;
            OP_LINK:                  st <= ST_LNK0;
            default:                  st <= ST_STAT;
          endcase
        end
        ST_CFG: if (mem_ack) begin
          cfg_nib <= mem_rdata[11:8];
          st      <= ST_HND;
        end
        ST_HND:  if (hnd_done) st <= ST_STAT;
        ST_LNK0: if (mem_ack) st <= ST_LNK1;
        ST_LNK1: if (mem_ack) st <= ST_STAT;
        ST_STAT: if (mem_ack) st <= ST_PLO;
        ST_PLO: if (mem_ack) begin
          ptr_lo <= mem_rdata;
          st     <= ST_PHI;
        end
        ST_PHI: if (mem_ack) begin
          cx_flag  <= c_int;
          irq      <= c_int;
          stat_upd <= 1'b1;
          if (c_susp) begin
            cu_state <= CU_SUSP;
            nxt      <= lk_next;
            nxt_vld  <= !lk_null;
            st       <= ST_IDLE;
          end else if (lk_null) begin
            cu_state <= CU_IDLE;
            st       <= ST_IDLE;
          end else begin
            blk <= lk_next;
            st  <= ST_BUSY;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_hnd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (hnd_req && !hnd_done) |=> hnd_req);
  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  assert_irq_with_upd_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> stat_upd);
  assert_cx_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_upd && !irq) |-> !cx_flag);
  assert_upd_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    stat_upd |=> !stat_upd);
  assert_active_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req || hnd_req) |-> (cu_state == CU_ACT));
  assert_susp_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (cu_state == CU_SUSP) |-> (!mem_req && !hnd_req));
endmodule

// File: tb/tb_cle_exec.sv
`timescale 1ns/1ps
module tb_cle_exec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] head_ptr = '0;
  logic        link_up = 1'b1;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        hnd_req;
  logic [2:0]  hnd_op;
  logic [3:0]  hnd_len;
  logic [31:0] hnd_addr;
  logic        hnd_done = 1'b0;
  logic [1:0]  cu_state;
  logic        cx_flag, irq, stat_upd;

  cle_exec #(.ADDR_W(32), .CFG_BYTES(14)) dut (.*);

  always #5 clk = ~clk;

  logic [15:0] mem [0:1023];
  logic [55:0] exq[$];
  int nchecks = 0, nfail = 0;
  int lat = 0, hlat = 1, wcnt = 0, hcnt = 0;
  int n_irq = 0, n_upd = 0, cycles = 0;
  int exp_irq, exp_upd, exp_cu, exp_cx;
  logic [31:0] sv_ptr = '0;
  bit sv_vld = 0, finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [55:0] act, input logic [55:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [55:0] ev(input logic [7:0] k, input logic [31:0] a, input logic [15:0] d);
    return {k, a, d};
  endfunction

  function automatic logic [15:0] rd(input logic [31:0] a);
    return mem[a[10:1]];
  endfunction

  task automatic put_blk(input logic [31:0] a, input logic [15:0] cmd, input logic [31:0] lnk, input logic [15:0] p8);
    mem[a[10:1]]       = 16'h0;
    mem[(a + 2) >> 1]  = cmd;
    mem[(a + 4) >> 1]  = lnk[15:0];
    mem[(a + 6) >> 1]  = lnk[31:16];
    mem[(a + 8) >> 1]  = p8;
    mem[(a + 10) >> 1] = 16'h1234;
  endtask

  // behavioural expectation of the walk: memory writes and handler calls
  task automatic expect_walk(input logic [31:0] head);
    logic [31:0] p, nx;
    logic [15:0] c;
    int n;
    bit nul;
    p = sv_vld ? sv_ptr : head;
    sv_vld = 0;
    exp_irq = 0; exp_upd = 0;
    forever begin
      exq.push_back(ev(1, p, 16'h4000));
      c = rd(p + 2);
      case (c[2:0])
        3'd1: exq.push_back(ev(2, p, {9'd0, 3'd1, 4'd6}));
        3'd2: begin
          n = int'(rd(p + 8) >> 8) & 15;
          if (n < 4) n = 4;
          if (n > 14) n = 14;
          exq.push_back(ev(2, p, {9'd0, 3'd2, 4'(n)}));
        end
        3'd3: exq.push_back(ev(2, p, {9'd0, 3'd3, 4'd0}));
        3'd4: exq.push_back(ev(2, p, {9'd0, 3'd4, 4'd0}));
        3'd5: begin
          exq.push_back(ev(1, p + 8, link_up ? 16'h8000 : 16'h0));
          exq.push_back(ev(1, p + 10, 16'h0));
        end
        default: ;
      endcase
      exq.push_back(ev(1, p, (c[2:0] <= 5) ? 16'hA000 : 16'h8000));
      nx = {rd(p + 6), rd(p + 4)};
      nul = c[15] || nx == 0 || nx == 32'hFFFF_FFFF;
      exp_upd++;
      exp_irq += c[13];
      exp_cx = c[13];
      if (c[14]) begin exp_cu = 1; sv_ptr = nx; sv_vld = !nul; break; end
      if (nul) begin exp_cu = 0; break; end
      p = nx;
    end
  endtask

  // memory responder and event comparison
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req && !rst) begin
      if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0;
        mem_ack = 1'b1;
        if (mem_we) begin
          if (exq.size() == 0) chk(0, "R2 unexpected write", ev(1, mem_addr, mem_wdata), 0);
          else begin
            logic [55:0] e;
            e = exq.pop_front();
            chk(e == ev(1, mem_addr, mem_wdata), "R2/R10 write sequence", ev(1, mem_addr, mem_wdata), e);
          end
          chk(cu_state == 2, "R12 active during walk", 56'(cu_state), 2);
          mem[mem_addr[10:1]] = mem_wdata;
        end else mem_rdata = mem[mem_addr[10:1]];
      end
    end
  end

  // handler responder
  always @(negedge clk) begin
    if (hnd_done) hnd_done = 1'b0;
    else if (hnd_req && !rst) begin
      if (hcnt < hlat) hcnt++;
      else begin
        logic [55:0] e, a;
        hcnt = 0;
        hnd_done = 1'b1;
        a = ev(2, hnd_addr, {9'd0, hnd_op, hnd_len});
        if (exq.size() == 0) chk(0, "R9 unexpected handler call", a, 0);
        else begin
          e = exq.pop_front();
          chk(e == a, "R8/R9 handler call", a, e);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (irq) n_irq++;
    if (stat_upd) n_upd++;
  end

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        chk(0, "watchdog", 56'(cycles), 0);
        summary();
      end
    end
  end

  task automatic run(input logic [31:0] head, input string tag, input bit poke);
    int k;
    expect_walk(head);
    n_irq = 0; n_upd = 0;
    @(negedge clk);
    head_ptr = head;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cu_state == 2, {tag, " R12 becomes active"}, 56'(cu_state), 2);
    k = 0;
    while (cu_state == 2 && k < 5000) begin
      @(negedge clk);
      k++;
      if (poke && k == 4) begin
        head_ptr = 32'h300;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    repeat (3) @(negedge clk);
    chk(exq.size() == 0, {tag, " R4/R5 trace fully consumed"}, 56'(exq.size()), 0);
    exq.delete();
    chk(cu_state == 2'(exp_cu), {tag, " R4/R6 final unit state"}, 56'(cu_state), 56'(exp_cu));
    chk(cx_flag == 1'(exp_cx), {tag, " R7 cx flag"}, 56'(cx_flag), 56'(exp_cx));
    chk(n_irq == exp_irq, {tag, " R7 irq pulses"}, 56'(n_irq), 56'(exp_irq));
    chk(n_upd == exp_upd, {tag, " R11 status strobes"}, 56'(n_upd), 56'(exp_upd));
    chk(!mem_req && !hnd_req, {tag, " R6 bus quiet after walk"}, 56'({mem_req, hnd_req}), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
    // list A: noop+int, configure nibble 2 (clamped up), link test with end-of-list
    put_blk(32'h100, 16'h2000, 32'h120, 16'h0);
    put_blk(32'h120, 16'h0002, 32'h140, 16'h0200);
    put_blk(32'h140, 16'h8005, 32'h160, 16'h0);
    // list B: address setup, transmit+suspend, configure nibble 15 (clamped down)+int, multicast, op6+int with all-ones link
    put_blk(32'h200, 16'h0001, 32'h220, 16'h0);
    put_blk(32'h220, 16'h4004, 32'h240, 16'h0);
    put_blk(32'h240, 16'h2002, 32'h260, 16'h0F00);
    put_blk(32'h260, 16'h0003, 32'h280, 16'h0);
    put_blk(32'h280, 16'h2006, 32'hFFFF_FFFF, 16'h0);
    // list C: op7, link test with link down and zero link
    put_blk(32'h300, 16'h0007, 32'h320, 16'h0);
    put_blk(32'h320, 16'h0005, 32'h0, 16'h0);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cu_state == 0, "R1 reset unit state", 56'(cu_state), 0);
    chk(!cx_flag && !irq && !stat_upd, "R1 reset flags", 56'({cx_flag, irq, stat_upd}), 0);
    chk(!mem_req && !hnd_req, "R1 reset no requests", 56'({mem_req, hnd_req}), 0);

    lat = 0; link_up = 1'b1;
    run(32'h100, "A", 1'b1);
    lat = 2;
    run(32'h200, "B1", 1'b0);
    run(32'h100, "B2 resume", 1'b0);
    lat = 1; link_up = 1'b0; hlat = 0;
    run(32'h300, "C", 1'b0);
    chk(mem[(32'h328) >> 1] == 16'h0, "R10 link-down value in memory", 56'(mem[(32'h328) >> 1]), 0);
    chk(mem[(32'h300) >> 1] == 16'h8000, "R3 op7 status in memory", 56'(mem[(32'h300) >> 1]), 56'h8000);
    summary();
  end
endmodule